// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the serial control port of a clock synthesizer. A system master reaches a small bank of configuration bytes over a two-wire serial bus (clock line and open-drain data line). The slave samples both bus lines with a much faster system clock, finds start and stop conditions, and moves bytes most significant bit first, with an acknowledge slot after every byte. The configuration bytes are presented in parallel on `regs_o` so the synthesizer logic can use them directly.

The protocol has no register sub-address. A write transfer carries the device address with the direction bit clear, then a command byte and a byte-count byte whose contents are acknowledged and discarded, then data for byte 0, byte 1 and onward in order. To change a later byte, the master must rewrite every earlier byte in the same transfer. A read transfer carries the address with the direction bit set. The slave then sends a count byte followed by byte 0, byte 1 and so on, and it continues only while the master acknowledges.

The data line is driven only through `sda_oe`. When it is 1 the pad pulls the line low, and when it is 0 the line is released.

Top module: `cfg_twowire_slave`

## Requirements
- R1: After reset every configuration byte on `regs_o` is 0x00 and `sda_oe` is 0 (line released).
- R2: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged by holding the data line low during the ninth clock's high period.
- R3: Any other address byte is not acknowledged, and every later byte up to the next start is neither acknowledged nor stored.
- R4: In a write, the two bytes after the address (command, count) are acknowledged but not stored. Data bytes then land in byte 0, 1, 2 and onward in arrival order, MSB first, where byte k occupies `regs_o[8k+7:8k]`.
- R5: Data bytes at positions NUM_REGS up to MAX_XFER-1 (8 and 9 by default) are acknowledged and discarded. The data byte at position MAX_XFER (the eleventh by default) is not acknowledged.
- R6: In a read, the slave sends the count byte (value NUM_REGS, 0x08 by default) and then byte 0, byte 1 and onward, MSB first, each after a master acknowledge. It pulls the line low only for 0 bits, and the stored bytes do not change.
- R7: A master NACK after a read byte ends the transmission. The slave keeps the line released, so further clocked bytes read as 0xFF.
- R8: A start condition in the middle of a byte aborts the transfer and begins a new address reception.
- R9: A stop condition ends the transfer. A partly received data byte is not stored, bytes clocked after the stop are not acknowledged, and `sda_oe` changes only while the synchronized clock line is low, except on a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock, at least 16x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_o | output | NUM_REGS*8 | Configuration bytes, byte k at bits 8k+7:8k |

## Verification
Both bus lines pass through a two-flop synchronizer plus one edge register, so a response on `sda_oe` appears three to four system cycles after the bus clock edge that causes it. The bench therefore drives each bus phase for ten system cycles and samples the wired data line in the middle of every clock-high phase, well after that latency. A stored byte is updated on the clock falling edge that follows its eighth bit, so `regs_o` is compared only after the stop condition, when every write has settled. Each read value is rebuilt from the eight mid-high samples of the wired line.

// File: rtl/cfg_twowire_slave.sv
module cfg_twowire_slave #(
  parameter int NUM_REGS = 8,
  parameter int MAX_XFER = 10,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);

  localparam int IDXW = $clog2(MAX_XFER + 1);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(MAX_XFER);
  localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);
  localparam logic [7:0] WR_ADDR = {DEV_ADDR, 1'b0};
  localparam logic [7:0] RD_ADDR = {DEV_ADDR, 1'b1};

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK} state_t;
  typedef enum logic [1:0] {P_ADDR, P_CMD, P_CNT, P_DATA} phase_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;
  logic       scl_h, scl_rise, scl_fall, start_det, stop_det;

  state_t          state;
  phase_t          phase;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic            rw;
  logic            go;
  logic [IDXW-1:0] idx;
  logic [7:0]      regs [NUM_REGS];
  logic [7:0]      rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_q <= scl_s[1];
      sda_q <= sda_s[1];
    end
  end

  assign scl_h     = scl_s[1];
  assign scl_rise  = scl_h & ~scl_q;
  assign scl_fall  = ~scl_h & scl_q;
  assign start_det = scl_h & scl_q & sda_q & ~sda_s[1];
  assign stop_det  = scl_h & scl_q & ~sda_q & sda_s[1];

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDXW'(i)) rd_byte = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      phase  <= P_ADDR;
      bitcnt <= '0;
      shreg  <= '0;
      rw     <= 1'b0;
      go     <= 1'b0;
      idx    <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (start_det) begin
      state  <= S_RX;
      phase  <= P_ADDR;
      bitcnt <= '0;
      rw     <= 1'b0;
      go     <= 1'b0;
      idx    <= '0;
    end else if (stop_det) begin
      state <= S_IDLE;
      rw    <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s[1]};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            unique case (phase)
              P_ADDR: begin
                if (shreg == WR_ADDR) begin
                  state <= S_RXACK;
                  phase <= P_CMD;
                end else if (shreg == RD_ADDR) begin
                  state <= S_RXACK;
                  rw    <= 1'b1;
                end else begin
                  state <= S_IDLE;
                end
              end
              P_CMD: begin
                state <= S_RXACK;
                phase <= P_CNT;
              end
              P_CNT: begin
                state <= S_RXACK;
                phase <= P_DATA;
                idx   <= '0;
              end
              P_DATA: begin
                if (idx != LAST_IDX) begin
                  state <= S_RXACK;
                  for (int i = 0; i < NUM_REGS; i++)
                    if (idx == IDXW'(i)) regs[i] <= shreg;
                  idx <= idx + 1'b1;
                end else begin
                  state <= S_IDLE;
                end
              end
            endcase
          end
        end
        S_RXACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              state <= S_TX;
              shreg <= CNT_BYTE;
              idx   <= '0;
            end else begin
              state <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              state <= S_TXACK;
              go    <= 1'b0;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        S_TXACK: begin
          if (scl_rise) begin
            if (sda_s[1]) state <= S_IDLE;
            else          go    <= 1'b1;
          end else if (scl_fall && go) begin
            if (idx == LAST_IDX) begin
              state <= S_IDLE;
            end else begin
              state  <= S_TX;
              shreg  <= rd_byte;
              idx    <= idx + 1'b1;
              bitcnt <= '0;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sda_oe = (state == S_RXACK) | ((state == S_TX) & ~shreg[7]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regs[g];
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (regs_o == '0 && !sda_oe));

  p_foreign_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RX && phase == P_ADDR && bitcnt == 4'd8 && scl_fall &&
     shreg[7:1] != DEV_ADDR && !start_det && !stop_det)
    |=> (state == S_IDLE && !sda_oe));

  p_header_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != P_DATA && $past(phase != P_DATA)) |-> $stable(regs_o));

  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX);

  p_read_keeps_regs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rw && $past(rw)) |-> $stable(regs_o));

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_q);

endmodule

// File: tb/cfg_twowire_slave_tb.sv
module cfg_twowire_slave_tb_top;

  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NREG*8-1:0] regs_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  cfg_twowire_slave #(.NUM_REGS(NREG), .MAX_XFER(10), .DEV_ADDR(7'h69)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o));

  localparam logic [23:0] WVEC [4] = '{24'hA5_3C_0F, 24'h00_FF_81, 24'h12_34_56, 24'hFE_01_80};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (10) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qwait();
      scl_m = 1'b1; qwait(); qwait();
      scl_m = 1'b0; qwait();
    end
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    ack = ~sda_line;
    qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait();
      scl_m = 1'b1; qwait();
      b[i] = sda_line;
      qwait();
      scl_m = 1'b0;
    end
    qwait();
    sda_m = ~give_ack; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
    sda_m = 1'b1;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] rb;
    logic [NREG*8-1:0] exp_regs;

    repeat (5) @(posedge clk);
    #1;
    check("R1 regs after reset", 64'(regs_o), 64'h0);
    check("R1 sda_oe after reset", 64'(sda_oe), 64'h0);
    rst_n = 1'b1;
    qwait();
    check("R1 regs after release", 64'(regs_o), 64'h0);

    for (int v = 0; v < 4; v++) begin
      bus_start();
      write_byte(8'hD2, ack); check("R2 write address ack", 64'(ack), 64'h1);
      write_byte(8'hFF, ack); check("R4 command ack", 64'(ack), 64'h1);
      write_byte(8'h5A, ack); check("R4 count ack", 64'(ack), 64'h1);
      write_byte(WVEC[v][23:16], ack); check("R4 data0 ack", 64'(ack), 64'h1);
      write_byte(WVEC[v][15:8], ack);  check("R4 data1 ack", 64'(ack), 64'h1);
      write_byte(WVEC[v][7:0], ack);   check("R4 data2 ack", 64'(ack), 64'h1);
      bus_stop();
      check("R4 bytes 0..2 stored in order", 64'(regs_o[23:0]),
            64'({WVEC[v][7:0], WVEC[v][15:8], WVEC[v][23:16]}));
      bus_start();
      write_byte(8'hD3, ack); check("R2 read address ack", 64'(ack), 64'h1);
      read_byte(1'b1, rb); check("R6 count byte", 64'(rb), 64'h08);
      read_byte(1'b1, rb); check("R6 byte0", 64'(rb), 64'(WVEC[v][23:16]));
      read_byte(1'b1, rb); check("R6 byte1", 64'(rb), 64'(WVEC[v][15:8]));
      read_byte(1'b0, rb); check("R6 byte2", 64'(rb), 64'(WVEC[v][7:0]));
      bus_stop();
      check("R6 regs unchanged by read", 64'(regs_o[23:0]),
            64'({WVEC[v][7:0], WVEC[v][15:8], WVEC[v][23:16]}));
    end

    bus_start();
    write_byte(8'hD2, ack);
    write_byte(8'h00, ack);
    write_byte(8'h00, ack);
    for (int i = 0; i < 10; i++) begin
      write_byte(8'(8'h10 + i), ack);
      check(i < NREG ? "R4 full write ack" : "R5 excess byte ack", 64'(ack), 64'h1);
    end
    write_byte(8'hEE, ack); check("R5 eleventh byte nack", 64'(ack), 64'h0);
    bus_stop();
    for (int i = 0; i < NREG; i++) exp_regs[i*8 +: 8] = 8'(8'h10 + i);
    check("R5 only first NUM_REGS stored", 64'(regs_o), 64'(exp_regs));

    bus_start();
    write_byte(8'hA0, ack); check("R3 foreign address nack", 64'(ack), 64'h0);
    write_byte(8'h00, ack); check("R3 later byte nack", 64'(ack), 64'h0);
    write_byte(8'h00, ack);
    write_byte(8'h77, ack); check("R3 data byte nack", 64'(ack), 64'h0);
    bus_stop();
    check("R3 regs untouched", 64'(regs_o), 64'(exp_regs));

    bus_start();
    write_byte(8'hD0, ack); check("R3 neighbour address nack", 64'(ack), 64'h0);
    bus_stop();

    bus_start();
    write_byte(8'hD3, ack);
    read_byte(1'b1, rb);
    read_byte(1'b0, rb); check("R7 byte0 before nack", 64'(rb), 64'h10);
    read_byte(1'b1, rb); check("R7 released after nack", 64'(rb), 64'hFF);
    check("R7 sda_oe low after nack", 64'(sda_oe), 64'h0);
    bus_stop();

    bus_start();
    send_bits(8'hD2, 4);
    bus_start();
    write_byte(8'hD2, ack); check("R8 address after restart ack", 64'(ack), 64'h1);
    write_byte(8'h00, ack);
    write_byte(8'h00, ack);
    write_byte(8'hC7, ack); check("R8 data ack", 64'(ack), 64'h1);
    bus_stop();
    exp_regs[7:0] = 8'hC7;
    check("R8 byte0 written after restart", 64'(regs_o), 64'(exp_regs));

    bus_start();
    write_byte(8'hD2, ack);
    write_byte(8'h00, ack);
    write_byte(8'h00, ack);
    write_byte(8'h3B, ack);
    send_bits(8'h99, 5);
    bus_stop();
    exp_regs[7:0] = 8'h3B;
    check("R9 partial byte discarded", 64'(regs_o), 64'(exp_regs));
    write_byte(8'hD2, ack); check("R9 no ack after stop", 64'(ack), 64'h0);
    sda_m = 1'b1; scl_m = 1'b1; qwait();
    check("R9 sda released after stop", 64'(sda_oe), 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule